// File: doc/BRIEF.md
# CAN Interrupt Aggregation and Fault-Confinement State Unit

This unit gathers every interrupt source of a CAN controller into one 29-bit status word: sixteen mailbox event flags, a one-hot fault-confinement state, and five sticky frame-error flags. Software controls a 29-bit interrupt mask through two write-only strobes. One strobe sets mask bits and the other clears them, so no read-modify-write is ever needed. A single level interrupt output is raised while any unmasked status bit is set.

The fault-confinement state is derived from the transmit and receive error counters and the bus-off flag of the protocol core. The counters are also exposed in one read-only register. Reading the status register consumes the frame-error flags. The level-type bits (mailbox flags and fault state) are unaffected by that read. The register port is plain control: a write strobe with a select and data, and a read strobe with a select that returns data in the same cycle. There is no back-pressure, because every access completes in one cycle.

Top module: `can_event_irq_unit`

## Requirements
- R1: After reset the mask is zero, the interrupt is low, the frame-error bits are zero, and the status state field shows error-active only (bit 16).
- R2: Status bits 15:0 follow the mailbox flag inputs with one cycle of delay.
- R3: A write with select 0 (set strobe) sets each mask bit whose data bit is 1. Data bits that are 0 leave their mask bits unchanged.
- R4: A write with select 1 (clear strobe) clears each mask bit whose data bit is 1. Data bits that are 0 leave their mask bits unchanged.
- R5: The mask (read select 2) is read-only. A write with select 2, 3 or 4 leaves the mask unchanged.
- R6: The interrupt output is 1 exactly when some bit of status AND mask is 1, across all 29 bits.
- R7: Frame-error pulses latch into status bits 24 (CRC), 25 (stuffing), 26 (acknowledge), 27 (form) and 28 (bit error). Each latched bit stays set until the status register is read.
- R8: A status read (read strobe with select 3) clears bits 28:24 and leaves bits 19:0 unchanged. A frame-error pulse in the same cycle as the read leaves its bit set.
- R9: Status bits 19:16 are one-hot and are registered one cycle after the counters. Warning (bit 17) applies when either counter is at least 96. Error-passive (bit 18) applies when either counter is at least 128. Otherwise error-active (bit 16) applies. The higher state takes precedence.
- R10: While the bus-off input is high, bit 19 (bus-off) is the state, whatever the counter values.
- R11: Read select 4 returns the receive count in bits 7:0 and the transmit count in bits 23:16, as registered one cycle after the inputs. All other bits are zero.
- R12: Status bits 23:20 and 31:29 read as zero. Read selects 0, 1 and 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mb_flags | input | 16 | Per-mailbox event levels |
| frame_err | input | 5 | One-cycle frame error pulses: CRC, stuffing, ack, form, bit |
| tx_err_cnt | input | 8 | Transmit error counter from the protocol core |
| rx_err_cnt | input | 8 | Receive error counter from the protocol core |
| bus_off | input | 1 | Transmit counter has reached 256 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write register select |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe (side effects) |
| rd_sel | input | 3 | Read register select |
| rd_data | output | 32 | Read data, combinational from rd_sel |
| irq | output | 1 | Interrupt request |

## Verification
Two of this block's functions can act in the same cycle: latching a frame-error pulse and the read-clear of the status register. The bench first latches a CRC error. It then issues a status read in the same cycle as a stuffing-error pulse. The CRC bit must be gone afterwards and the stuffing bit must remain set. The bench also confirms that the read returned the value held before the clear.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int MB_COUNT = 16;
  localparam int FS_COUNT = 4;
  localparam int FE_COUNT = 5;
  localparam int ST_LO    = MB_COUNT;
  localparam int FE_LO    = 24;
  localparam int STAT_W   = FE_LO + FE_COUNT;
  localparam int GAP_W    = FE_LO - ST_LO - FS_COUNT;
  localparam int CNT_W    = 8;
  localparam int REG_W    = 32;
  localparam int SEL_W    = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_SETMASK = 3'd0,
    SEL_CLRMASK = 3'd1,
    SEL_MASK    = 3'd2,
    SEL_STATUS  = 3'd3,
    SEL_ERRCNT  = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    FS_ACTIVE  = 2'd0,
    FS_WARNING = 2'd1,
    FS_PASSIVE = 2'd2,
    FS_BUSOFF  = 2'd3
  } fault_state_e;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import can_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_stb,
  input  logic              clr_stb,
  input  logic [STAT_W-1:0] bits,
  output logic [STAT_W-1:0] mask_q
);
  logic [STAT_W-1:0] set_v, clr_v;

  always_comb begin
    set_v = set_stb ? bits : '0;
    clr_v = clr_stb ? bits : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= (mask_q | set_v) & ~clr_v;
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && !clr_stb) |=> ((mask_q & $past(bits)) == $past(bits))); // R3
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((mask_q & $past(bits)) == '0)); // R4
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(mask_q)); // R5
endmodule

// File: rtl/event_status_reg.sv
module event_status_reg
  import can_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MB_COUNT-1:0] mb_flags,
  input  logic [FE_COUNT-1:0] frame_err,
  input  logic                rd_clear,
  output logic [MB_COUNT-1:0] mb_q,
  output logic [FE_COUNT-1:0] fe_q
);
  logic [FE_COUNT-1:0] fe_d;

  always_comb begin
    fe_d = (rd_clear ? '0 : fe_q) | frame_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb_q <= '0;
      fe_q <= '0;
    end else begin
      mb_q <= mb_flags;
      fe_q <= fe_d;
    end
  end

  AST_FE_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fe_q & $past(frame_err)) == $past(frame_err))); // R8
  AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clear |=> ((fe_q & $past(fe_q)) == $past(fe_q))); // R7
  AST_FE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && frame_err == '0) |=> (fe_q == '0)); // R8
endmodule

// File: rtl/fault_state_decoder.sv
module fault_state_decoder
  import can_irq_pkg::*;
#(
  parameter int WARN_LIMIT    = 96,
  parameter int PASSIVE_LIMIT = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    tec,
  input  logic [CNT_W-1:0]    rec,
  input  logic                bus_off,
  output logic [FS_COUNT-1:0] state_bits,
  output logic [CNT_W-1:0]    tec_q,
  output logic [CNT_W-1:0]    rec_q
);
  localparam logic [CNT_W-1:0] WARN_L = WARN_LIMIT[CNT_W-1:0];
  localparam logic [CNT_W-1:0] PASS_L = PASSIVE_LIMIT[CNT_W-1:0];

  fault_state_e state_d, state_q;

  always_comb begin
    if (bus_off)                              state_d = FS_BUSOFF;
    else if (tec >= PASS_L || rec >= PASS_L)  state_d = FS_PASSIVE;
    else if (tec >= WARN_L || rec >= WARN_L)  state_d = FS_WARNING;
    else                                      state_d = FS_ACTIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_ACTIVE;
      tec_q   <= '0;
      rec_q   <= '0;
    end else begin
      state_q <= state_d;
      tec_q   <= tec;
      rec_q   <= rec;
    end
  end

  for (genvar g = 0; g < FS_COUNT; g++) begin : g_onehot
    assign state_bits[g] = (state_q == fault_state_e'(g));
  end

  AST_BUSOFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |=> (state_q == FS_BUSOFF)); // R10
  AST_QUIET_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_off && tec < WARN_L && rec < WARN_L) |=> (state_q == FS_ACTIVE)); // R9
  AST_PASSIVE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_off && (tec >= PASS_L || rec >= PASS_L)) |=> (state_q == FS_PASSIVE)); // R9
endmodule

// File: rtl/can_event_irq_unit.sv
module can_event_irq_unit
  import can_irq_pkg::*;
#(
  parameter int WARN_LIMIT    = 96,
  parameter int PASSIVE_LIMIT = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         mb_flags,
  input  logic [4:0]          frame_err,
  input  logic [7:0]          tx_err_cnt,
  input  logic [7:0]          rx_err_cnt,
  input  logic                bus_off,
  input  logic                wr_en,
  input  logic [2:0]          wr_sel,
  input  logic [31:0]         wr_data,
  input  logic                rd_en,
  input  logic [2:0]          rd_sel,
  output logic [31:0]         rd_data,
  output logic                irq
);
  logic [STAT_W-1:0]   mask_q;
  logic [STAT_W-1:0]   status;
  logic [MB_COUNT-1:0] mb_q;
  logic [FE_COUNT-1:0] fe_q;
  logic [FS_COUNT-1:0] state_bits;
  logic [CNT_W-1:0]    tec_q, rec_q;
  logic                set_stb, clr_stb, rd_clear;
  logic [REG_W-STAT_W-1:0] unused_wr_hi;

  assign unused_wr_hi = wr_data[REG_W-1:STAT_W];
  assign set_stb  = wr_en && (reg_sel_e'(wr_sel) == SEL_SETMASK);
  assign clr_stb  = wr_en && (reg_sel_e'(wr_sel) == SEL_CLRMASK);
  assign rd_clear = rd_en && (reg_sel_e'(rd_sel) == SEL_STATUS);

  irq_mask_reg u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (set_stb),
    .clr_stb (clr_stb),
    .bits    (wr_data[STAT_W-1:0]),
    .mask_q  (mask_q)
  );

  event_status_reg u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .mb_flags  (mb_flags),
    .frame_err (frame_err),
    .rd_clear  (rd_clear),
    .mb_q      (mb_q),
    .fe_q      (fe_q)
  );

  fault_state_decoder #(
    .WARN_LIMIT    (WARN_LIMIT),
    .PASSIVE_LIMIT (PASSIVE_LIMIT)
  ) u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .tec        (tx_err_cnt),
    .rec        (rx_err_cnt),
    .bus_off    (bus_off),
    .state_bits (state_bits),
    .tec_q      (tec_q),
    .rec_q      (rec_q)
  );

  assign status = {fe_q, {GAP_W{1'b0}}, state_bits, mb_q};
  assign irq    = |(status & mask_q);

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_MASK:   rd_data = {{(REG_W-STAT_W){1'b0}}, mask_q};
      SEL_STATUS: rd_data = {{(REG_W-STAT_W){1'b0}}, status};
      SEL_ERRCNT: rd_data = {8'h00, tec_q, 8'h00, rec_q};
      default:    rd_data = '0;
    endcase
  end

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(state_bits) == 1)); // R9
  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && wr_data[STAT_W-1:0] == {STAT_W{1'b1}}) |=> !irq); // R6
endmodule

// File: tb/can_event_irq_unit_bench.sv
`timescale 1ns/1ps
module can_event_irq_unit_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] mb_flags = '0;
  logic [4:0]  frame_err = '0;
  logic [7:0]  tx_err_cnt = '0, rx_err_cnt = '0;
  logic        bus_off = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int failures = 0;
  logic [28:0] exp_mask;

  always #5 clk = ~clk;

  can_event_irq_unit u_can_event_irq_unit (
    .clk(clk), .rst_n(rst_n), .mb_flags(mb_flags), .frame_err(frame_err),
    .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt), .bus_off(bus_off),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  function automatic logic [3:0] exp_state(input int t, input int r, input logic bo);
    if (bo) return 4'b1000;
    if (t >= 128 || r >= 128) return 4'b0100;
    if (t >= 96 || r >= 96) return 4'b0010;
    return 4'b0001;
  endfunction

  initial begin : watchdog
    #1500000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1 reset state
    rd(3'd3, v); chk("R1 status", v, 32'h0001_0000);
    rd(3'd2, v); chk("R1 mask", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 mailbox flags walk
    for (int i = 0; i < 16; i++) begin
      mb_flags = 16'h1 << i;
      tick();
      rd(3'd3, v); chk("R2 mailbox bit", {16'h0, v[15:0]}, {16'h0, 16'h1 << i});
    end
    mb_flags = '0; tick();

    // R3 set strobe
    exp_mask = '0;
    for (int i = 0; i < 29; i++) begin
      wr(3'd0, 32'h1 << i);
      exp_mask[i] = 1'b1;
      rd(3'd2, v); chk("R3 set bit", v, {3'b0, exp_mask});
      wr(3'd1, 32'h0);
      rd(3'd2, v); chk("R4 zero clear no effect", v, {3'b0, exp_mask});
    end
    // R4 clear strobe on even bits
    wr(3'd1, 32'h1555_5555);
    exp_mask = exp_mask & ~29'h1555_5555;
    rd(3'd2, v); chk("R4 clear even", v, {3'b0, exp_mask});
    wr(3'd0, 32'h0);
    rd(3'd2, v); chk("R3 zero set no effect", v, {3'b0, exp_mask});
    // R5 read-only mask
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R5 mask write ignored", v, {3'b0, exp_mask});
    wr(3'd3, 32'h0000_0000);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R5 other writes ignored", v, {3'b0, exp_mask});

    // R6 interrupt sweep, status = mb bit3 + active bit16
    wr(3'd1, 32'h1FFF_FFFF);
    chk("R6 no mask no irq", {31'b0, irq}, 32'h0);
    mb_flags = 16'h0008; tick();
    for (int i = 0; i < 29; i++) begin
      wr(3'd1, 32'h1FFF_FFFF);
      wr(3'd0, 32'h1 << i);
      chk("R6 irq per bit", {31'b0, irq}, {31'b0, (i == 3 || i == 16)});
    end
    wr(3'd1, 32'h1FFF_FFFF);
    mb_flags = '0;

    // R7 frame error latching, R8 read clear
    wr(3'd0, 32'h1F00_0000);
    for (int k = 0; k < 5; k++) begin
      frame_err = 5'h1 << k; tick(); frame_err = '0; tick(); tick();
      rd(3'd3, v); chk("R7 frame bit latched", v, 32'h0001_0000 | (32'h1 << (24 + k)));
      chk("R7 irq from frame bit", {31'b0, irq}, 32'h1);
      rd_en = 1; rd_sel = 3'd3; tick(); rd_en = 0;
      rd(3'd3, v); chk("R8 read clears frame bits", v, 32'h0001_0000);
      chk("R8 irq drops", {31'b0, irq}, 32'h0);
    end
    // R8 level bits kept across read
    mb_flags = 16'hA5A5; tick();
    rd_en = 1; rd_sel = 3'd3; tick(); rd_en = 0;
    rd(3'd3, v); chk("R8 level bits kept", v, 32'h0001_A5A5);
    mb_flags = '0; tick();
    // R8 collision: CRC latched, then read with stuffing pulse
    frame_err = 5'b00001; tick(); frame_err = '0;
    rd_sel = 3'd3; #1 v = rd_data;
    chk("R8 read value before clear", v, 32'h0101_0000);
    rd_en = 1; frame_err = 5'b00010; tick(); rd_en = 0; frame_err = '0;
    rd(3'd3, v); chk("R8 same-cycle pulse kept", v, 32'h0201_0000);
    rd_en = 1; rd_sel = 3'd3; tick(); rd_en = 0;
    wr(3'd1, 32'h1FFF_FFFF);

    // R9/R11 counter sweep
    for (int t = 0; t < 256; t++) begin
      for (int j = 0; j < 6; j++) begin
        int r;
        r = (j == 0) ? 0 : (j == 1) ? 95 : (j == 2) ? 96 : (j == 3) ? 127 : (j == 4) ? 128 : 255;
        tx_err_cnt = t[7:0]; rx_err_cnt = r[7:0];
        tick();
        rd(3'd3, v);
        chk("R9 state tx sweep", {28'h0, v[19:16]}, {28'h0, exp_state(t, r, 1'b0)});
        rd(3'd4, v);
        chk("R11 errcnt tx sweep", v, {8'h0, t[7:0], 8'h0, r[7:0]});
        tx_err_cnt = r[7:0]; rx_err_cnt = t[7:0];
        tick();
        rd(3'd3, v);
        chk("R9 state rx sweep", {28'h0, v[19:16]}, {28'h0, exp_state(r, t, 1'b0)});
        chk("R12 reserved bits zero", {v[31:29], 5'h0, v[23:20]}, 32'h0);
      end
    end

    // R10 bus-off override
    bus_off = 1; tx_err_cnt = 0; rx_err_cnt = 0; tick();
    rd(3'd3, v); chk("R10 bus-off low counts", {28'h0, v[19:16]}, 32'h8);
    tx_err_cnt = 8'd200; rx_err_cnt = 8'd130; tick();
    rd(3'd3, v); chk("R10 bus-off high counts", {28'h0, v[19:16]}, 32'h8);
    wr(3'd0, 32'h0008_0000);
    chk("R6 irq on bus-off", {31'b0, irq}, 32'h1);
    bus_off = 0; tx_err_cnt = 0; rx_err_cnt = 0; tick();
    rd(3'd3, v); chk("R10 release to active", {28'h0, v[19:16]}, 32'h1);
    chk("R6 irq cleared on leave", {31'b0, irq}, 32'h0);

    // R12 write-only and unused selects read zero
    rd(3'd0, v); chk("R12 sel0 zero", v, 32'h0);
    rd(3'd1, v); chk("R12 sel1 zero", v, 32'h0);
    for (int s = 5; s < 8; s++) begin
      rd(s[2:0], v); chk("R12 unused sel zero", v, 32'h0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule